// File: doc/BRIEF.md
# Out-of-Band Egress Backpressure Gate

This block sits in a MAC transmit path and decides, one frame at a time, whether the next frame may begin. An external backpressure level, coming from outside the MAC, can hold back frame starts. Each candidate frame carries a class tag, either regular data or a pause/PFC control frame. The gate issues a one-cycle start grant for an admitted frame. Once a frame is granted it is tracked as on the wire until the transmitter reports its end. While a frame is on the wire, backpressure cannot cut it.

Four settings shape the behaviour:
- An off switch takes the backpressure input out of play.
- A policy bit picks between two behaviours. The strict policy holds every frame class in either duplex. The legacy policy lets control frames through and ignores backpressure completely in half duplex.
- A bypass bit chooses whether the backpressure level goes through a local two-flop synchroniser or is used as it arrives, in which case it must already be in the transmit clock domain.
- The duplex input is used by the legacy policy.

A registered status output shows whether the gate currently holds back at least one frame class. The gate is separate from pause-frame flow control and has no effect on it.

Top module: `egress_hold_gate`

## Requirements
- R1: With `cfg_bp_off`=1 the backpressure input has no effect: every request made while no frame is on the wire is granted, and `bp_active` stays 0.
- R2: With `cfg_legacy`=0 (strict), effective backpressure blocks the start of both data frames (`req_class`=0) and control frames (`req_class`=1), in both half duplex (`cfg_half_duplex`=1) and full duplex.
- R3: With `cfg_legacy`=1, a control frame (`req_class`=1) is never blocked by backpressure.
- R4: With `cfg_legacy`=1 and `cfg_half_duplex`=1, backpressure is ignored entirely: data frames are granted and `bp_active` is 0.
- R5: With `cfg_sync_bypass`=1, the level of `bp_in` sampled at a clock edge governs the grant decision taken at that same edge.
- R6: With `cfg_sync_bypass`=0, `bp_in` passes through a two-flop synchroniser, so it governs the decision two clock edges later than in bypass.
- R7: A grant is issued only when no frame is on the wire. A granted frame stays on the wire, whatever backpressure does, until `frame_end` is sampled high. The next grant can come at the following edge at the earliest.
- R8: `bp_active` is registered. It is 1 after an edge exactly when, at that edge, the bp-off switch is 0, effective backpressure is 1, and the policy is strict or the duplex is full.
- R9: After synchronous reset, `start_grant` and `bp_active` are 0, no frame is on the wire, and the synchroniser holds 0.
- R10: `start_grant` is a single-cycle pulse. It is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_in | input | 1 | External backpressure level |
| cfg_bp_off | input | 1 | 1 = ignore backpressure input |
| cfg_legacy | input | 1 | 0 = strict policy, 1 = legacy policy |
| cfg_sync_bypass | input | 1 | 1 = use bp_in without synchroniser |
| cfg_half_duplex | input | 1 | 1 = MAC in half duplex |
| req_valid | input | 1 | A frame is waiting to start |
| req_class | input | 1 | Class of waiting frame: 0 data, 1 pause/PFC |
| frame_end | input | 1 | Current frame has finished on the wire |
| start_grant | output | 1 | One-cycle pulse: waiting frame may start |
| bp_active | output | 1 | Gating currently blocks at least one class |

## Verification
A wrong internal state shows up at the ports within one or two edges. If the on-wire flag is stuck set, grants stop after the first frame. If it is stuck clear, grants come back-to-back or while a frame is on the wire, both of which show on `start_grant` at the next edge. A synchroniser with the wrong depth, or a bypass mux with the wrong polarity, moves the first blocked grant and the rise of `bp_active` by one or more cycles after a `bp_in` edge. A policy term that is wrong shows up as a grant or block of the wrong class, or as a wrong status, at the edge right after the configuration in question is applied.

// File: rtl/egress_gate_pkg.sv
package egress_gate_pkg;
  typedef enum logic {
    CLS_DATA = 1'b0,
    CLS_CTRL = 1'b1
  } frame_class_e;

  localparam int unsigned DEFAULT_SYNC_STAGES = 2;
endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  input  logic bypass,
  output logic bp_out
);
  localparam int unsigned LAST = (STAGES > 0) ? STAGES - 1 : 0;

  logic synced;

  generate
    if (STAGES == 0) begin : g_none
      assign synced = raw_in;
    end else begin : g_chain
      logic [LAST:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else begin
          chain[0] <= raw_in;
          for (int i = 1; i <= int'(LAST); i++) chain[i] <= chain[i-1];
        end
      end
      assign synced = chain[LAST];
    end
  endgenerate

  assign bp_out = bypass ? raw_in : synced;
endmodule

// File: rtl/hold_policy.sv
module hold_policy
  import egress_gate_pkg::*;
(
  input  logic         bp_eff,
  input  logic         off,
  input  logic         legacy,
  input  logic         half_duplex,
  input  frame_class_e cls,
  output logic         blocked,
  output logic         any_blocked
);
  logic hold_data, hold_ctrl;

  always_comb begin
    hold_data = 1'b0;
    hold_ctrl = 1'b0;
    if (!off && bp_eff) begin
      if (!legacy) begin
        hold_data = 1'b1;
        hold_ctrl = 1'b1;
      end else if (!half_duplex) begin
        hold_data = 1'b1;
      end
    end
    blocked     = (cls == CLS_CTRL) ? hold_ctrl : hold_data;
    any_blocked = hold_data | hold_ctrl;
  end
endmodule

// File: rtl/start_tracker.sv
module start_tracker (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_blocked,
  input  logic frame_end,
  output logic grant,
  output logic busy
);
  logic grant_next;

  assign grant_next = !busy && req_valid && !req_blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      busy  <= 1'b0;
    end else begin
      grant <= grant_next;
      if (busy) busy <= !frame_end;
      else      busy <= grant_next;
    end
  end
endmodule

// File: rtl/egress_hold_gate.sv
module egress_hold_gate
  import egress_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic bp_in,
  input  logic cfg_bp_off,
  input  logic cfg_legacy,
  input  logic cfg_sync_bypass,
  input  logic cfg_half_duplex,
  input  logic req_valid,
  input  logic req_class,
  input  logic frame_end,
  output logic start_grant,
  output logic bp_active
);
  logic         bp_eff;
  logic         req_blocked;
  logic         any_blocked;
  logic         busy;
  frame_class_e cls;

  assign cls = frame_class_e'(req_class);

  bp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_in (bp_in),
    .bypass (cfg_sync_bypass),
    .bp_out (bp_eff)
  );

  hold_policy u_policy (
    .bp_eff      (bp_eff),
    .off         (cfg_bp_off),
    .legacy      (cfg_legacy),
    .half_duplex (cfg_half_duplex),
    .cls         (cls),
    .blocked     (req_blocked),
    .any_blocked (any_blocked)
  );

  start_tracker u_track (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_blocked (req_blocked),
    .frame_end   (frame_end),
    .grant       (start_grant),
    .busy        (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) bp_active <= 1'b0;
    else     bp_active <= any_blocked;
  end
endmodule

// File: rtl/egress_hold_gate_chk.sv
module egress_hold_gate_chk (
  input logic clk,
  input logic rst,
  input logic cfg_bp_off,
  input logic cfg_legacy,
  input logic cfg_half_duplex,
  input logic req_valid,
  input logic req_class,
  input logic frame_end,
  input logic start_grant,
  input logic bp_active,
  input logic bp_eff,
  input logic busy
);
  logic on_wire;

  always_ff @(posedge clk) begin
    if (rst) on_wire <= 1'b0;
    else     on_wire <= (on_wire || start_grant) && !frame_end;
  end

  a_r1_off_no_status: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_bp_off) |-> !bp_active);

  a_r2_strict_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(bp_eff && !cfg_bp_off && !cfg_legacy) |-> !start_grant);

  a_r3_ctrl_passes: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_legacy && req_valid && req_class && !busy) |-> start_grant);

  a_r4_half_ignored: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_legacy && cfg_half_duplex) |-> !bp_active);

  a_r7_no_cut: assert property (@(posedge clk) disable iff (rst)
    on_wire |-> !start_grant);

  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    start_grant |=> !start_grant);
endmodule

bind egress_hold_gate egress_hold_gate_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_bp_off      (cfg_bp_off),
  .cfg_legacy      (cfg_legacy),
  .cfg_half_duplex (cfg_half_duplex),
  .req_valid       (req_valid),
  .req_class       (req_class),
  .frame_end       (frame_end),
  .start_grant     (start_grant),
  .bp_active       (bp_active),
  .bp_eff          (bp_eff),
  .busy            (busy)
);

// File: tb/egress_hold_gate_test.sv
module egress_hold_gate_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bp_in = 0, cfg_bp_off = 0, cfg_legacy = 0, cfg_sync_bypass = 0;
  logic cfg_half_duplex = 0, req_valid = 0, req_class = 0, frame_end = 0;
  logic start_grant, bp_active;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  // bench model state
  bit m_p1 = 0, m_p2 = 0, m_busy = 0, m_prev_grant = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  egress_hold_gate uut (
    .clk(clk), .rst(rst), .bp_in(bp_in), .cfg_bp_off(cfg_bp_off),
    .cfg_legacy(cfg_legacy), .cfg_sync_bypass(cfg_sync_bypass),
    .cfg_half_duplex(cfg_half_duplex), .req_valid(req_valid),
    .req_class(req_class), .frame_end(frame_end),
    .start_grant(start_grant), .bp_active(bp_active)
  );

  function automatic bit eff_bp();
    return cfg_sync_bypass ? bp_in : m_p2;
  endfunction

  function automatic bit exp_blocked();
    if (cfg_bp_off || !eff_bp()) return 0;
    if (!cfg_legacy) return 1;
    if (cfg_half_duplex) return 0;
    return !req_class;
  endfunction

  function automatic bit exp_status();
    return !cfg_bp_off && eff_bp() && (!cfg_legacy || !cfg_half_duplex);
  endfunction

  function automatic string pick_tag();
    if (m_busy) return "R7";
    if (cfg_bp_off) return "R1";
    if (cfg_legacy && cfg_half_duplex) return "R4";
    if (cfg_legacy && req_class) return "R3";
    if (!cfg_legacy) return "R2";
    return cfg_sync_bypass ? "R5" : "R6";
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // call right after a negedge once inputs are set
  task automatic cyc(input string tag_in);
    bit g_exp, s_exp;
    string tag;
    tag = (tag_in != "") ? tag_in : pick_tag();
    if (rst) begin
      g_exp = 0; s_exp = 0;
    end else begin
      g_exp = !m_busy && req_valid && !exp_blocked();
      s_exp = exp_status();
    end
    @(posedge clk);
    #1;
    check(tag, "start_grant", start_grant, g_exp);
    check((tag_in != "") ? tag_in : "R8", "bp_active", bp_active, s_exp);
    if (m_prev_grant) check("R10", "grant pulse", start_grant, 1'b0);
    if (rst) begin
      m_p1 = 0; m_p2 = 0; m_busy = 0;
    end else begin
      m_p2 = m_p1; m_p1 = bp_in;
      m_busy = m_busy ? !frame_end : g_exp;
    end
    m_prev_grant = g_exp;
  endtask

  task automatic set_in(bit bp, bit off, bit leg, bit byp, bit half, bit rv, bit rc, bit fe);
    @(negedge clk);
    bp_in = bp; cfg_bp_off = off; cfg_legacy = leg; cfg_sync_bypass = byp;
    cfg_half_duplex = half; req_valid = rv; req_class = rc; frame_end = fe;
  endtask

  initial begin
    void'($urandom(32'd1234));
    // reset (R9)
    rst = 1;
    repeat (3) begin set_in(1, 0, 0, 0, 0, 1, 0, 0); cyc("R9"); end
    set_in(0, 0, 0, 1, 0, 0, 0, 0); rst = 0; cyc("R9");

    // R5: bypass, strict, bp rises -> blocked at same edge
    set_in(1, 0, 0, 1, 0, 1, 0, 0); cyc("R5");
    set_in(1, 0, 0, 1, 1, 1, 1, 0); cyc("R2");
    set_in(0, 0, 0, 1, 0, 1, 0, 0); cyc("R5");   // granted
    // R7: frame on wire, bp rises, no new grant until frame_end
    set_in(1, 0, 0, 1, 0, 1, 0, 0); cyc("R7");
    set_in(0, 0, 0, 1, 0, 1, 0, 0); cyc("R7");
    set_in(0, 0, 0, 1, 0, 1, 0, 1); cyc("R7");   // end sampled
    set_in(0, 0, 0, 1, 0, 1, 0, 0); cyc("R7");   // next grant
    set_in(0, 0, 0, 1, 0, 0, 0, 1); cyc("R7");

    // R6: synchronised path, bp rises; two-edge latency
    set_in(0, 0, 0, 0, 0, 0, 0, 0); cyc("R6");
    set_in(0, 0, 0, 0, 0, 0, 0, 0); cyc("R6");
    set_in(1, 0, 0, 0, 0, 0, 0, 0); cyc("R6");
    set_in(1, 0, 0, 0, 0, 0, 0, 0); cyc("R6");
    set_in(1, 0, 0, 0, 0, 1, 0, 0); cyc("R6");   // now blocked
    set_in(0, 0, 0, 0, 0, 1, 0, 0); cyc("R6");
    set_in(0, 0, 0, 0, 0, 1, 0, 0); cyc("R6");
    set_in(0, 0, 0, 0, 0, 1, 0, 0); cyc("R6");   // grant
    set_in(0, 0, 0, 0, 0, 0, 0, 1); cyc("R7");

    // R3 / R4 / R1 directed
    set_in(1, 0, 1, 1, 0, 1, 1, 0); cyc("R3");
    set_in(1, 0, 1, 1, 0, 0, 0, 1); cyc("R3");
    set_in(1, 0, 1, 1, 0, 1, 0, 0); cyc("R8");
    set_in(1, 0, 1, 1, 1, 1, 0, 0); cyc("R4");
    set_in(1, 0, 1, 1, 1, 0, 0, 1); cyc("R4");
    set_in(1, 1, 0, 1, 0, 1, 0, 0); cyc("R1");
    set_in(1, 1, 0, 1, 0, 0, 0, 1); cyc("R1");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      bit off, leg, byp, half;
      off = cfg_bp_off; leg = cfg_legacy; byp = cfg_sync_bypass; half = cfg_half_duplex;
      if (($urandom % 40) == 0) begin
        off = ($urandom % 5) == 0; leg = $urandom; byp = $urandom; half = $urandom;
      end
      set_in((($urandom % 8) == 0) ? !bp_in : bp_in, off, leg, byp, half,
             ($urandom % 3) != 0, $urandom, ($urandom % 4) == 0);
      cyc("");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule